// File: doc/BRIEF.md
# Full-Duplex SPI Packet Shift Engine

This block is the data path of an SPI master. A single shift register does both directions of the transfer. A transmit word is loaded into it in parallel. The word then leaves on MOSI, most significant bit first, one bit per clock cycle. In the same cycles the bits coming back on MISO enter at the low end of the same register and replace the transmit data.

MISO is captured on the falling clock edge by a dedicated re-timing flop. The rising edge that launches MOSI then shifts the captured bit into the register. After a full word has gone through, the register contents are copied into a receive holding register, and a one-cycle valid pulse marks the new word. If another transmit word is offered at that moment, it is loaded on the same edge, so packets follow each other with no idle cycle. If no word is offered, the engine stops: SCLK is gated off and MOSI is held low.

The serial clock is the block clock, gated by `sclk_en`. Chip select and rate division belong to the surrounding logic.

Top module: `spi_pkt_shifter`

## Requirements
- R1: While `rst_n` is low, and for at least two rising edges after it goes high, the block is held in reset. After reset, `sclk_en`=0, `mosi`=0, `rx_valid`=0, `rx_data`=0 and `par_q`=0. Once the internal reset has been released, `tx_ready`=1.
- R2: A word is accepted on a rising edge where `tx_valid` and `tx_ready` are both high. In the next cycle `par_q` equals that word, `sclk_en`=1 and `mosi` equals the word's bit WIDTH-1.
- R3: While `sclk_en` is high, each rising edge shifts `par_q` one place toward the MSB and places the re-timed MISO bit in bit 0. `mosi` therefore presents the transmit bits MSB first, one per cycle.
- R4: MISO is sampled on the falling clock edge. A change on `miso` between that falling edge and the next rising edge has no effect on the received word.
- R5: A packet lasts WIDTH cycles of `sclk_en`. On the edge that ends it, `rx_data` takes the full received word (first received bit in the MSB). `rx_valid` is high for exactly one cycle, the first cycle in which `rx_data` shows that word.
- R6: `tx_ready` is high during the last bit cycle of a packet. If `tx_valid` is high in that cycle, the next word is loaded on the same edge as the receive capture. Consecutive `rx_valid` pulses are then exactly WIDTH cycles apart, with `sclk_en` never dropping between them.
- R7: If `tx_valid` is low in the last bit cycle, the block goes idle after that edge. `sclk_en`=0, `mosi`=0 and `tx_ready`=1, and `par_q` holds the received word.
- R8: `rx_data` changes only in a cycle where `rx_valid` is high.
- R9: While the block is idle and `tx_valid` is low, changes on `tx_data` have no effect: `sclk_en`, `par_q` and `rx_data` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the serial clock while gated on |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_data | input | WIDTH | Next transmit word |
| tx_valid | input | 1 | Transmit word is offered |
| tx_ready | output | 1 | Transmit word is taken on this edge if offered |
| rx_data | output | WIDTH | Receive holding register |
| rx_valid | output | 1 | One-cycle pulse: new word in `rx_data` |
| par_q | output | WIDTH | Parallel view of the shift register |
| sclk_en | output | 1 | Serial clock gate, high while bits are exchanged |
| mosi | output | 1 | Serial data out, MSB first |
| miso | input | 1 | Serial data in |

## Verification
The slave is modelled as a loopback, either straight or inverting. A packet exchanged in isolation checks the load, the MSB-first order and the stop into idle one cycle at a time. A back-to-back stream of words with alternating, sparse, all-ones and all-zeros bits checks that no bits are lost, reordered or smeared across packet boundaries, and that no gap cycle appears between packets. The inverting loopback tells received data apart from transmit data left behind in the register. A disturbance placed on MISO only in the half cycle before each rising edge separates falling-edge sampling from rising-edge sampling. Idle cycles with changing `tx_data` show that nothing starts without a handshake.

// File: rtl/spi_pkt_pkg.sv
`timescale 1ns/1ps
package spi_pkt_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } spi_state_e;
endpackage

// File: rtl/spi_rst_sync.sv
`timescale 1ns/1ps
// Asserts asynchronously, releases on the second rising edge.
module spi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) pipe_q <= '0;
    else           pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_miso_retime.sv
`timescale 1ns/1ps
// Samples serial input on the falling edge; held until the next shift edge.
module spi_miso_retime (
  input  logic clk,
  input  logic rst_n,
  input  logic miso,
  output logic miso_q
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) miso_q <= 1'b0;
    else        miso_q <= miso;
  end
endmodule

// File: rtl/spi_bit_counter.sv
`timescale 1ns/1ps
module spi_bit_counter #(
  parameter int WIDTH = 8,
  localparam int CW   = (WIDTH > 2) ? $clog2(WIDTH) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic last
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clear | step;
    if (clear) cnt_d = '0;
    else       cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == CW'(WIDTH - 1));
endmodule

// File: rtl/spi_shift_path.sv
`timescale 1ns/1ps
// One register for both directions: a 2:1 mux per flop picks load or shift.
module spi_shift_path #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] reg_d;
  logic             reg_en;

  assign reg_en = load | shift;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      if (i == 0) begin : g_lsb
        assign shifted[i] = ser_in;
      end else begin : g_up
        assign shifted[i] = q[i-1];
      end
      assign reg_d[i] = load ? par_in[i] : shifted[i];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q[i] <= 1'b0;
        else if (reg_en) q[i] <= reg_d[i];
      end
    end
  endgenerate
endmodule

// File: rtl/spi_pkt_shifter.sv
`timescale 1ns/1ps
module spi_pkt_shifter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [WIDTH-1:0] rx_data,
  output logic             rx_valid,
  output logic [WIDTH-1:0] par_q,
  output logic             sclk_en,
  output logic             mosi,
  input  logic             miso
);
  import spi_pkt_pkg::*;

  logic       rst_sync_n;
  logic       miso_q;
  logic       bit_last;
  logic       running;
  logic       accept;
  logic       finish;
  logic       do_load;
  logic       do_shift;
  spi_state_e state_q, state_d;
  logic [WIDTH-1:0] rx_q, rx_d;
  logic             rx_we;
  logic             rxv_q;

  spi_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_sync_n)
  );

  spi_miso_retime u_retime (
    .clk(clk), .rst_n(rst_sync_n), .miso(miso), .miso_q(miso_q)
  );

  // Control decode
  always_comb begin
    running  = (state_q == ST_RUN);
    tx_ready = rst_sync_n & (~running | bit_last);
    accept   = tx_valid & tx_ready;
    finish   = running & bit_last;
    do_load  = accept;
    do_shift = running & ~accept;
    state_d  = state_q;
    if (accept)      state_d = ST_RUN;
    else if (finish) state_d = ST_IDLE;
  end

  spi_bit_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n),
    .clear(accept | finish), .step(running), .last(bit_last)
  );

  spi_shift_path #(.WIDTH(WIDTH)) u_sr (
    .clk(clk), .rst_n(rst_sync_n),
    .load(do_load), .shift(do_shift),
    .par_in(tx_data), .ser_in(miso_q), .q(par_q)
  );

  // Receive capture takes the value the final shift produces
  always_comb begin
    rx_we = finish;
    rx_d  = {par_q[WIDTH-2:0], miso_q};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      rxv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rxv_q   <= rx_we;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rx_q <= '0;
    else if (rx_we)  rx_q <= rx_d;
  end

  assign rx_data  = rx_q;
  assign rx_valid = rxv_q;
  assign sclk_en  = running;
  assign mosi     = running & par_q[WIDTH-1];
endmodule

// File: rtl/spi_pkt_shifter_chk.sv
`timescale 1ns/1ps
module spi_pkt_shifter_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_i,
  input logic [WIDTH-1:0] tx_data,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [WIDTH-1:0] rx_data,
  input logic             rx_valid,
  input logic [WIDTH-1:0] par_q,
  input logic             sclk_en,
  input logic             mosi
);
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_i)
    (tx_valid && tx_ready) |=> (sclk_en && par_q == $past(tx_data)
                                && mosi == $past(tx_data[WIDTH-1])));

  assert_shift_R3: assert property (@(posedge clk) disable iff (!rst_i)
    (sclk_en && !tx_ready) |=> (par_q[WIDTH-1:1] == $past(par_q[WIDTH-2:0])));

  assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_i)
    rx_valid |=> !rx_valid);

  assert_stream_R6: assert property (@(posedge clk) disable iff (!rst_i)
    (sclk_en && tx_ready && tx_valid) |=> (sclk_en && rx_valid));

  assert_stop_R7: assert property (@(posedge clk) disable iff (!rst_i)
    (sclk_en && tx_ready && !tx_valid) |=> (!sclk_en && rx_valid));

  assert_idle_mosi_R7: assert property (@(posedge clk) disable iff (!rst_i)
    !sclk_en |-> !mosi);

  assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rst_i)
    !rx_valid |-> $stable(rx_data));

  assert_idle_stays_R9: assert property (@(posedge clk) disable iff (!rst_i)
    (!sclk_en && !tx_valid) |=> (!sclk_en && $stable(par_q)));
endmodule

bind spi_pkt_shifter spi_pkt_shifter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_i(rst_sync_n), .tx_data(tx_data), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
  .par_q(par_q), .sclk_en(sclk_en), .mosi(mosi)
);

// File: tb/spi_pkt_shifter_test.sv
`timescale 1ns/1ps
module spi_pkt_shifter_test;
  localparam int W = 8;
  localparam int NV = 10;
  // {transmit word, expected received word} with a straight loopback
  localparam logic [2*W-1:0] VEC [0:NV-1] = '{
    16'hA5A5, 16'h5A5A, 16'hFFFF, 16'h0000, 16'h8080,
    16'h0101, 16'hC3C3, 16'h3C3C, 16'h7E7E, 16'h9696
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] tx_data;
  logic         tx_valid;
  logic         tx_ready;
  logic [W-1:0] rx_data;
  logic         rx_valid;
  logic [W-1:0] par_q;
  logic         sclk_en;
  logic         mosi;
  logic         miso;
  logic         inv;
  logic         spoil = 1'b0;

  int tests = 0;
  int fails = 0;
  int wr_idx = 0;
  int rd_idx = 0;
  int cyc = 0;
  int last_rx = 0;
  logic gap_arm = 1'b0;
  logic finished = 1'b0;
  logic [W-1:0] exp_mem [0:63];

  always #10 clk = ~clk;

  // Slave loopback; disturbance only in the half cycle before each rising edge
  assign miso = mosi ^ inv ^ spoil;

  always begin
    @(negedge clk); #5 spoil = 1'b1;
    @(posedge clk); #5 spoil = 1'b0;
  end

  spi_pkt_shifter #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .par_q(par_q), .sclk_en(sclk_en), .mosi(mosi), .miso(miso)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // Receive monitor: word contents (R5, R4) and packet spacing (R6)
  always @(negedge clk) begin
    cyc++;
    if (rx_valid) begin
      check("R5 rx word", rx_data, exp_mem[rd_idx]);
      if (gap_arm) check("R6 packet spacing", cyc - last_rx, W);
      gap_arm = 1'b1;
      last_rx = cyc;
      rd_idx++;
    end
  end

  // Stream words back to back; tx_valid held high across boundaries
  task automatic send_word(input logic [W-1:0] w);
    tx_data  = w;
    tx_valid = 1'b1;
    exp_mem[wr_idx] = w ^ {W{inv}};
    wr_idx++;
    while (!tx_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go_idle();
    tx_valid = 1'b0;
    repeat (W + 3) @(negedge clk);
    gap_arm = 1'b0;
  endtask

  // Single packet from idle with cycle-exact checks (R2, R3, R7)
  task automatic single_word(input logic [W-1:0] w);
    logic [W-1:0] e;
    e = w ^ {W{inv}};
    tx_data  = w;
    tx_valid = 1'b1;
    exp_mem[wr_idx] = e;
    wr_idx++;
    check("R2 ready in idle", tx_ready, 1);
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    check("R2 par_q loaded", par_q, w);
    check("R2 sclk_en on", sclk_en, 1);
    check("R2 first mosi is MSB", mosi, w[W-1]);
    for (int k = 1; k < W; k++) begin
      @(negedge clk);
      check("R3 mosi bit order", mosi, w[W-1-k]);
      check("R3 sclk_en held", sclk_en, 1);
    end
    check("R6 ready in last bit", tx_ready, 1);
    @(negedge clk);
    check("R7 sclk_en off", sclk_en, 0);
    check("R7 mosi low", mosi, 0);
    check("R7 ready idle", tx_ready, 1);
    check("R7 par_q holds rx word", par_q, e);
    check("R5 rx_valid pulse", rx_valid, 1);
    @(negedge clk);
    check("R5 rx_valid one cycle", rx_valid, 0);
    gap_arm = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [W-1:0] held_rx, held_par;
    rst_n    = 1'b0;
    tx_valid = 1'b0;
    tx_data  = '0;
    inv      = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 sclk_en", sclk_en, 0);
    check("R1 mosi", mosi, 0);
    check("R1 rx_valid", rx_valid, 0);
    check("R1 rx_data", rx_data, 0);
    check("R1 par_q", par_q, 0);
    check("R1 tx_ready", tx_ready, 1);

    single_word(8'hB4);

    // R9 idle with tx_valid low ignores tx_data
    held_rx  = rx_data;
    held_par = par_q;
    for (int k = 0; k < 6; k++) begin
      tx_data = 8'h11 * k[7:0];
      @(negedge clk);
      check("R9 stays idle", sclk_en, 0);
      check("R9 par_q unchanged", par_q, held_par);
      check("R8 rx_data unchanged", rx_data, held_rx);
    end

    // Table stream, straight loopback, no gaps (R5, R6)
    for (int i = 0; i < NV; i++) begin
      send_word(VEC[i][2*W-1:W]);
      exp_mem[wr_idx-1] = VEC[i][W-1:0];
    end
    go_idle();

    // Inverting loopback stream; spoil pulses test falling-edge sampling (R4)
    inv = 1'b1;
    send_word(8'h00);
    send_word(8'hFF);
    send_word(8'h6D);
    send_word(8'h80);
    go_idle();
    single_word(8'h01);
    inv = 1'b0;

    repeat (W + 2) @(negedge clk);
    check("R5 all packets received", rd_idx, wr_idx);
    finish_run();
  end
endmodule